// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer with a small 32-bit register window. It counts down from a reload value. A slow tick-enable input, divided by a programmable power-of-two prescaler, drives the count, so the timeout does not depend on the bus clock. Software controls the block by writing 16-bit magic values to a key register. One value starts the countdown, one restarts it from the reload value, and one opens the prescaler, reload and early-warning registers for writing. Any other key value closes them again.

A value written to one of the three protected registers goes first into a shadow copy. It reaches the counter only after a fixed number of tick-enable pulses, to model a crossing into the slow domain. A per-register busy bit in the status word is set for that whole interval. The status word also carries a running bit, which stays set from the start command until reset.

When a prescaled period ends with the counter at zero, the block emits a one-cycle reset pulse, reloads and keeps counting. An optional early-warning flag is raised when the count steps down onto a programmed compare value.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, status (0x0C) reads 0, the prescaler (0x04) reads 0, the reload register (0x08) reads 0xFFF, the early-warning register (0x14) reads 0, and both outputs are low.
- R2: Writes to the prescaler (bits 3:0), reload (bits 11:0) and early-warning (bit 15 enable, bits 11:0 compare) registers take effect only after key value 0x5555 has been written to the key register (0x00). Otherwise they are ignored: read-back is unchanged and no busy bit is set.
- R3: Any write to the key register with a value other than 0x5555 in bits 15:0, including 0x0000, closes the protected registers again.
- R4: An accepted write sets its status busy bit (bit 0 prescaler, bit 1 reload, bit 3 early-warning). The bit clears on the third tick-enable pulse after the write, and only then does the counter use the new value. Status bit 2 always reads 0.
- R5: Key value 0xCCCC starts the countdown and sets status bit 8. No later key write or register write clears the running state. Before start, ticks produce no reset pulse.
- R6: The counter steps down once every D ticks, where D = 4 << min(code, 6), so code 6 and code 7 both give 256. With reload value R, `wdog_rst_o` pulses for exactly one cycle on the (R+1)*D-th tick after a start or restart.
- R7: After a reset pulse the counter reloads from the current reload value and keeps counting, so the pulses repeat.
- R8: Key value 0xAAAA, while running, restarts the countdown from the active reload value and clears the prescaler phase.
- R9: When the enable bit is set and the count steps down onto the compare value, `early_irq_o` rises and stays high. It falls when the early-warning register is written with bit 14 set, whether the registers are open or closed. Bit 14 always reads 0.
- R10: The version register (0x3F4) returns the revision 0x31 in bits 7:0, and the key register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse standing for one slow-clock period |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 12 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdog_rst_o | output | 1 | One-cycle reset request on timeout |
| early_irq_o | output | 1 | Early-warning interrupt level |

## Verification
Several properties are checked on every cycle. The reset pulse never lasts longer than one cycle, and it never occurs while the block is stopped. The running state never falls. The registers open only after the open key, and they close after any other key. A closed reload write never raises its busy bit, and a prescaler busy bit rises only after an accepted write. The early-warning flag holds until it is cleared. Some behaviours are visible only in the bench's scenarios: the exact timeout as a function of prescaler code and reload value, the three-tick commit latency, a restart taking the old reload value while an update is still pending, and the tick on which the early warning fires. The bench sweeps all eight prescaler codes and a range of reload values and computes each expected tick count arithmetically.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
   // register window (byte offsets)
   localparam int unsigned OFF_KEY  = 'h000;
   localparam int unsigned OFF_PRE  = 'h004;
   localparam int unsigned OFF_RLD  = 'h008;
   localparam int unsigned OFF_STAT = 'h00C;
   localparam int unsigned OFF_EWC  = 'h014;
   localparam int unsigned OFF_VER  = 'h3F4;

   // key register command values
   localparam logic [15:0] KEY_LOCK = 16'h0000;
   localparam logic [15:0] KEY_OPEN = 16'h5555;
   localparam logic [15:0] KEY_KICK = 16'hAAAA;
   localparam logic [15:0] KEY_GO   = 16'hCCCC;

   // synchronised register slots
   localparam int NSLOT    = 3;
   localparam int SLOT_W   = 16;
   localparam int SLOT_PRE = 0;
   localparam int SLOT_RLD = 1;
   localparam int SLOT_EWC = 2;

   // status word bit positions
   localparam int ST_PRE = 0;
   localparam int ST_RLD = 1;
   localparam int ST_WIN = 2;
   localparam int ST_EWC = 3;
   localparam int ST_RUN = 8;

   // early-warning register bits
   localparam int EWC_EN_BIT  = 15;
   localparam int EWC_CLR_BIT = 14;
endpackage

// File: rtl/kwd_sync.sv
`timescale 1ns/1ps
module kwd_sync #(
   parameter int          W          = 16,
   parameter logic [W-1:0] RST_VAL   = '0,
   parameter int          SYNC_TICKS = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] shadow_q,
   output logic [W-1:0] active_q,
   output logic         busy_q
);
   if (SYNC_TICKS == 0) begin : g_direct
      // no crossing modelled: shadow and active move together
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q <= RST_VAL;
            active_q <= RST_VAL;
         end else if (wr_en) begin
            shadow_q <= wr_data;
            active_q <= wr_data;
         end
      end
      assign busy_q = 1'b0;
   end else begin : g_counted
      localparam int CW = $clog2(SYNC_TICKS + 1);
      localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);
      logic [CW-1:0] cnt_q;
      logic          busy_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q <= RST_VAL;
            active_q <= RST_VAL;
            busy_r   <= 1'b0;
            cnt_q    <= '0;
         end else if (wr_en) begin
            shadow_q <= wr_data;
            busy_r   <= 1'b1;
            cnt_q    <= '0;
         end else if (busy_r && tick_en) begin
            if (cnt_q == LAST) begin
               active_q <= shadow_q;
               busy_r   <= 1'b0;
               cnt_q    <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
      assign busy_q = busy_r;
   end
endmodule

// File: rtl/kwd_regs.sv
`timescale 1ns/1ps
module kwd_regs #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter logic [7:0] VERSION = 8'h31,
   parameter logic [kwd_pkg::NSLOT-1:0][kwd_pkg::SLOT_W-1:0] SLOT_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [kwd_pkg::NSLOT-1:0][kwd_pkg::SLOT_W-1:0] slot_shadow,
   input  logic [kwd_pkg::NSLOT-1:0] slot_busy,
   input  logic                 running,
   output logic                 unlocked_o,
   output logic                 go_o,
   output logic                 kick_o,
   output logic                 ew_clr_o,
   output logic [kwd_pkg::NSLOT-1:0] slot_wr_o,
   output logic [kwd_pkg::NSLOT-1:0][kwd_pkg::SLOT_W-1:0] slot_wdata_o
);
   import kwd_pkg::*;

   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFF_VER);
   localparam logic [ADDR_W-1:0] A_EWC  = ADDR_W'(OFF_EWC);
   localparam logic [NSLOT-1:0][ADDR_W-1:0] SLOT_ADDR =
      {ADDR_W'(OFF_EWC), ADDR_W'(OFF_RLD), ADDR_W'(OFF_PRE)};

   logic        unlocked_q;
   logic        key_hit;
   logic [15:0] key_val;
   logic [DATA_W-1:0] status_w;

   assign key_hit = bus_wr && (bus_addr == A_KEY);
   assign key_val = bus_wdata[15:0];
   assign go_o    = key_hit && (key_val == KEY_GO);
   assign kick_o  = key_hit && (key_val == KEY_KICK);
   assign ew_clr_o = bus_wr && (bus_addr == A_EWC) && bus_wdata[EWC_CLR_BIT];

   // any key write decides the lock: only the open value leaves it open
   always_ff @(posedge clk) begin
      if (!rst_n)       unlocked_q <= 1'b0;
      else if (key_hit) unlocked_q <= (key_val == KEY_OPEN);
   end
   assign unlocked_o = unlocked_q;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot_wr
      assign slot_wr_o[i]    = bus_wr && unlocked_q && (bus_addr == SLOT_ADDR[i]);
      assign slot_wdata_o[i] = bus_wdata[SLOT_W-1:0] & SLOT_MASK[i];
   end

   always_comb begin
      status_w         = '0;
      status_w[ST_PRE] = slot_busy[SLOT_PRE];
      status_w[ST_RLD] = slot_busy[SLOT_RLD];
      status_w[ST_WIN] = 1'b0;
      status_w[ST_EWC] = slot_busy[SLOT_EWC];
      status_w[ST_RUN] = running;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_STAT)     bus_rdata = status_w;
      else if (bus_addr == A_VER) bus_rdata = DATA_W'(VERSION);
      else begin
         for (int i = 0; i < NSLOT; i++)
            if (bus_addr == SLOT_ADDR[i]) bus_rdata = DATA_W'(slot_shadow[i]);
      end
   end

   logic unused_hi;
   assign unused_hi = ^bus_wdata[DATA_W-1:SLOT_W];
endmodule

// File: rtl/kwd_core.sv
`timescale 1ns/1ps
module kwd_core #(
   parameter int CNT_W    = 12,
   parameter int PRE_W    = 4,
   parameter int MAX_CODE = 6,
   parameter int BASE_LOG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             go,
   input  logic             kick,
   input  logic [PRE_W-1:0] div_code,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             ew_en,
   input  logic [CNT_W-1:0] ew_cmp,
   input  logic             ew_clr,
   output logic             running_o,
   output logic             bark_o,
   output logic             ew_flag_o
);
   localparam int PC_W = BASE_LOG + MAX_CODE;

   logic [PC_W-1:0]  pcnt_q;
   logic [PC_W-1:0]  period_last;
   logic [PC_W:0]    span;
   logic [PRE_W-1:0] code_eff;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_dec;
   logic             run_q, bark_q, ewf_q;
   logic             restart, step;

   always_comb begin
      code_eff    = (div_code > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : div_code;
      span        = (PC_W+1)'(1) << (int'(code_eff) + BASE_LOG);
      period_last = PC_W'(span - (PC_W+1)'(1));
      restart     = go | (kick & run_q);
      step        = run_q & tick_en & ~restart & (pcnt_q >= period_last);
      cnt_dec     = cnt_q - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pcnt_q <= '0;
         cnt_q  <= '0;
         bark_q <= 1'b0;
      end else begin
         bark_q <= 1'b0;
         if (go) run_q <= 1'b1;
         if (restart) begin
            cnt_q  <= reload_val;
            pcnt_q <= '0;
         end else if (run_q && tick_en) begin
            if (step) begin
               pcnt_q <= '0;
               if (cnt_q == '0) begin
                  bark_q <= 1'b1;
                  cnt_q  <= reload_val;
               end else begin
                  cnt_q <= cnt_dec;
               end
            end else begin
               pcnt_q <= pcnt_q + PC_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ewf_q <= 1'b0;
      else if (step && ew_en && (cnt_q != '0) && (cnt_dec == ew_cmp))
         ewf_q <= 1'b1;
      else if (ew_clr)
         ewf_q <= 1'b0;
   end

   assign running_o = run_q;
   assign bark_o    = bark_q;
   assign ew_flag_o = ewf_q;
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog #(
   parameter int         ADDR_W     = 12,
   parameter int         DATA_W     = 32,
   parameter int         CNT_W      = 12,
   parameter int         PRE_W      = 4,
   parameter int         MAX_CODE   = 6,
   parameter int         BASE_LOG   = 2,
   parameter int         SYNC_TICKS = 3,
   parameter logic [7:0] VERSION    = 8'h31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdog_rst_o,
   output logic              early_irq_o
);
   import kwd_pkg::*;

   if (CNT_W < 2 || CNT_W > EWC_CLR_BIT) begin : g_bad_cnt
      $error("keyed_wdog: CNT_W out of range");
   end
   if (DATA_W <= SLOT_W) begin : g_bad_data
      $error("keyed_wdog: DATA_W must exceed the slot width");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("keyed_wdog: ADDR_W too small for the register window");
   end
   if (BASE_LOG < 1 || MAX_CODE < 0 || (1 << PRE_W) <= MAX_CODE || PRE_W > CNT_W) begin : g_bad_pre
      $error("keyed_wdog: prescaler parameters inconsistent");
   end
   if (SYNC_TICKS < 0) begin : g_bad_sync
      $error("keyed_wdog: SYNC_TICKS negative");
   end

   localparam logic [SLOT_W-1:0] PRE_MASK = SLOT_W'((1 << PRE_W) - 1);
   localparam logic [SLOT_W-1:0] RLD_MASK = SLOT_W'((1 << CNT_W) - 1);
   localparam logic [SLOT_W-1:0] EWC_MASK = RLD_MASK | (SLOT_W'(1) << EWC_EN_BIT);
   localparam logic [NSLOT-1:0][SLOT_W-1:0] SLOT_MASK = {EWC_MASK, RLD_MASK, PRE_MASK};
   localparam logic [NSLOT-1:0][SLOT_W-1:0] SLOT_RST  = {SLOT_W'(0), RLD_MASK, SLOT_W'(0)};

   logic [NSLOT-1:0][SLOT_W-1:0] shadow_w, active_w, slot_wdata_w;
   logic [NSLOT-1:0]             busy_w, slot_wr_w;
   logic run_w, unlocked_w, go_w, kick_w, ew_clr_w;

   kwd_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION), .SLOT_MASK(SLOT_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .slot_shadow(shadow_w), .slot_busy(busy_w), .running(run_w),
      .unlocked_o(unlocked_w), .go_o(go_w), .kick_o(kick_w), .ew_clr_o(ew_clr_w),
      .slot_wr_o(slot_wr_w), .slot_wdata_o(slot_wdata_w)
   );

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      kwd_sync #(
         .W(SLOT_W), .RST_VAL(SLOT_RST[i]), .SYNC_TICKS(SYNC_TICKS)
      ) u_sync (
         .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
         .wr_en(slot_wr_w[i]), .wr_data(slot_wdata_w[i]),
         .shadow_q(shadow_w[i]), .active_q(active_w[i]), .busy_q(busy_w[i])
      );
   end

   kwd_core #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .MAX_CODE(MAX_CODE), .BASE_LOG(BASE_LOG)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .go(go_w), .kick(kick_w),
      .div_code(active_w[SLOT_PRE][PRE_W-1:0]),
      .reload_val(active_w[SLOT_RLD][CNT_W-1:0]),
      .ew_en(active_w[SLOT_EWC][EWC_EN_BIT]),
      .ew_cmp(active_w[SLOT_EWC][CNT_W-1:0]),
      .ew_clr(ew_clr_w),
      .running_o(run_w), .bark_o(wdog_rst_o), .ew_flag_o(early_irq_o)
   );

   logic unused_active;
   assign unused_active = ^active_w;
endmodule

// File: rtl/keyed_wdog_chk.sv
`timescale 1ns/1ps
module keyed_wdog_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [15:0]       key_data,
   input logic              bark,
   input logic              irq,
   input logic              running,
   input logic              unlocked,
   input logic [kwd_pkg::NSLOT-1:0] busy
);
   import kwd_pkg::*;

   // R6
   bark_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bark |=> !bark);

   // R6
   bark_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bark |-> running);

   // R5
   run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);

   // R2
   open_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_KEY) && key_data == KEY_OPEN));

   // R3
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_KEY) && key_data != KEY_OPEN) |=> !unlocked);

   // R2
   locked_rld_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_RLD) && !unlocked) |=> !$rose(busy[SLOT_RLD]));

   // R4
   pre_busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[SLOT_PRE]) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_PRE) && unlocked));

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(bus_wr && bus_addr == ADDR_W'(OFF_EWC) && key_data[EWC_CLR_BIT])) |=> irq);
endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .key_data(bus_wdata[15:0]), .bark(wdog_rst_o), .irq(early_irq_o),
   .running(run_w), .unlocked(unlocked_w), .busy(busy_w)
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb;
   localparam logic [11:0] A_KEY  = 12'h000;
   localparam logic [11:0] A_PRE  = 12'h004;
   localparam logic [11:0] A_RLD  = 12'h008;
   localparam logic [11:0] A_STAT = 12'h00C;
   localparam logic [11:0] A_EWC  = 12'h014;
   localparam logic [11:0] A_VER  = 12'h3F4;
   localparam int SYNC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   wire  [31:0] bus_rdata;
   wire         bark, irq;

   int n_tests = 0;
   int n_fail  = 0;
   int barks   = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   keyed_wdog u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wdog_rst_o(bark), .early_irq_o(irq)
   );

   always @(negedge clk) if (bark === 1'b1) barks++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic chk_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_en = 1'b1;
      end
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
   endtask

   // expects the pulse exactly on the n-th tick from now
   task automatic measure(input string req, input int n);
      int b0;
      b0 = barks;
      ticks(n - 1);
      check(req, 32'(barks - b0), 32'd0);
      ticks(1);
      check(req, 32'(barks - b0), 32'd1);
   endtask

   function automatic int divider(input int code);
      return 4 << ((code > 6) ? 6 : code);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_rd("R1", A_STAT, 32'h0);
      chk_rd("R1", A_PRE, 32'h0);
      chk_rd("R1", A_RLD, 32'hFFF);
      chk_rd("R1", A_EWC, 32'h0);
      check("R1", {30'd0, bark, irq}, 32'h0);
      // R10 version and key read-back
      chk_rd("R10", A_VER, 32'h31);
      chk_rd("R10", A_KEY, 32'h0);

      // R2 writes while closed are ignored
      wr(A_RLD, 32'h5);
      wr(A_PRE, 32'h3);
      wr(A_EWC, 32'h8002);
      chk_rd("R2", A_RLD, 32'hFFF);
      chk_rd("R2", A_PRE, 32'h0);
      chk_rd("R2", A_EWC, 32'h0);
      chk_rd("R2", A_STAT, 32'h0);

      // R3 other key values close the window
      wr(A_KEY, 32'h5555);
      wr(A_KEY, 32'h1234);
      wr(A_RLD, 32'h7);
      chk_rd("R3", A_RLD, 32'hFFF);
      wr(A_KEY, 32'h5555);
      wr(A_KEY, 32'h0000);
      wr(A_PRE, 32'h2);
      chk_rd("R3", A_PRE, 32'h0);
      chk_rd("R3", A_STAT, 32'h0);

      // R4 busy flags and commit latency
      wr(A_KEY, 32'h5555);
      wr(A_RLD, 32'h5);
      chk_rd("R4", A_STAT, 32'h2);
      chk_rd("R4", A_RLD, 32'h5);
      wr(A_PRE, 32'h0);
      chk_rd("R4", A_STAT, 32'h3);
      ticks(SYNC - 1);
      chk_rd("R4", A_STAT, 32'h3);
      ticks(1);
      chk_rd("R4", A_STAT, 32'h0);
      wr(A_EWC, 32'h4003);
      chk_rd("R4", A_STAT, 32'h8);
      chk_rd("R9", A_EWC, 32'h3);
      ticks(SYNC);
      chk_rd("R4", A_STAT, 32'h0);
      wr(A_KEY, 32'h0000);

      // R5 idle before start
      ticks(40);
      check("R5", 32'(barks), 32'd0);
      chk_rd("R5", A_STAT, 32'h0);

      // R5 start, R6 first timeout, R7 repeat
      wr(A_KEY, 32'hCCCC);
      chk_rd("R5", A_STAT, 32'h100);
      measure("R6", 6 * 4);
      measure("R7", 6 * 4);
      wr(A_KEY, 32'h0000);
      wr(A_KEY, 32'h5555);
      wr(A_KEY, 32'h1111);
      chk_rd("R5", A_STAT, 32'h100);

      // R8 restart part way through a period
      ticks(10);
      wr(A_KEY, 32'hAAAA);
      measure("R8", 6 * 4);

      // R4 restart while an update is pending keeps the old value
      wr(A_KEY, 32'h5555);
      wr(A_RLD, 32'h9);
      wr(A_KEY, 32'hAAAA);
      measure("R4", 6 * 4);
      measure("R4", 10 * 4);

      // R6 sweep over every prescaler code
      for (int code = 0; code < 8; code++) begin
         for (int k = 0; k < 3; k++) begin
            int r;
            r = (k == 0) ? 0 : ((k == 1) ? 1 : 3);
            wr(A_KEY, 32'h5555);
            wr(A_PRE, 32'(code));
            wr(A_RLD, 32'(r));
            ticks(SYNC);
            wr(A_KEY, 32'hAAAA);
            measure("R6", (r + 1) * divider(code));
         end
      end

      // R6 and R7 sweep over reload values
      for (int r = 0; r < 16; r++) begin
         wr(A_KEY, 32'h5555);
         wr(A_PRE, 32'h0);
         wr(A_RLD, 32'(r));
         ticks(SYNC);
         wr(A_KEY, 32'hAAAA);
         measure("R6", (r + 1) * 4);
         measure("R7", (r + 1) * 4);
      end

      // R9 early warning at compare 3 with reload 7
      wr(A_KEY, 32'h5555);
      wr(A_EWC, 32'h8003);
      wr(A_RLD, 32'h7);
      ticks(SYNC);
      wr(A_KEY, 32'hAAAA);
      wr(A_EWC, 32'h4000);
      check("R9", {31'd0, irq}, 32'h0);
      ticks(15);
      check("R9", {31'd0, irq}, 32'h0);
      ticks(1);
      check("R9", {31'd0, irq}, 32'h1);
      ticks(4);
      check("R9", {31'd0, irq}, 32'h1);
      wr(A_EWC, 32'h4000);
      check("R9", {31'd0, irq}, 32'h0);
      chk_rd("R9", A_EWC, 32'h8003);

      // R9 disabled: no flag
      wr(A_KEY, 32'h5555);
      wr(A_EWC, 32'h0003);
      ticks(SYNC);
      wr(A_KEY, 32'hAAAA);
      wr(A_EWC, 32'h4000);
      ticks(20);
      check("R9", {31'd0, irq}, 32'h0);
      chk_rd("R5", A_STAT, 32'h100);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule